// File: doc/BRIEF.md
# Filtered Input Change Interrupt

This block captures up to 32 parallel input lines for a general-purpose I/O controller. Each line is first resynchronised into the clock domain. Software can then route it through a small glitch filter, line by line. The level that results is readable at any time. Any transition on that level, rising or falling, latches a pending bit for the line. A per-line mask decides whether a pending bit contributes to the single interrupt output.

Software configures the block through a small register port. Each register has a 3-bit word address and a single-cycle write or read strobe. Read data is registered, so it appears one cycle after the read strobe. The mask and the filter selection are each changed through an "on" address and an "off" address. At both, the ones in the written word pick the lines that change, and every other line keeps its value. Reading the pending register returns the pending word and clears the whole word in the same cycle. An edge that arrives in that same cycle is kept as pending.

Top module: `pio_change_irq`

Register addresses: 0 mask-on (write), 1 mask-off (write), 2 mask (read), 3 pending (read, clears), 4 filter-on (write), 5 filter-off (write), 6 filter state (read), 7 line level (read). A read of a write-only address returns zero.

## Requirements
- R1: A read of address 7 returns, for each line, the synchronised level of that line after its filter selection. Bit n of the result corresponds to pin n.
- R2: Writing to address 0 sets the mask bits where the written word has ones. Writing to address 1 clears the mask bits where the written word has ones. Address 2 reads the mask back.
- R3: A rising or a falling transition on the level of a line sets bit n of the pending register (address 3).
- R4: `irq_o` is high exactly when at least one line has both its pending bit and its mask bit set. A pending line whose mask bit is clear has no effect on `irq_o`.
- R5: A read of address 3 returns the pending word as it was before that read. The same read clears every pending bit.
- R6: When a line's transition is detected in the same cycle as a read of address 3, that line's pending bit is set after the read.
- R7: Writing to address 4 turns filtering on for the lines where the written word has ones. Writing to address 5 turns filtering off for those lines. Address 6 reads the filter selection back.
- R8: On a filtered line, a level seen at only one sampling edge is rejected and causes no pending bit. A level held for two consecutive sampling edges is accepted.
- R9: On an unfiltered line, a pin change made before clock edge 1 sets the pending bit at edge 3. On a filtered line, the same change sets the pending bit at edge 5.
- R10: After reset, the mask, the filter selection, the pending word and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | NLINES | Write data |
| rdata_o | output | NLINES | Read data, valid the cycle after `rd_en_i` |
| pins_i | input | NLINES | Asynchronous line inputs |
| irq_o | output | 1 | Interrupt request |

## Verification
An unfiltered pin change made before clock edge 1 sets its pending bit, and raises `irq_o` when the line is masked in, at edge 3. A filtered change does the same at edge 5. Read data is due one edge after the read strobe. The bench drives every input just after a falling edge and samples just after the next falling edge. It therefore counts edges exactly: it checks `irq_o` one edge before its due edge and again at it. To test a read that coincides with an edge, it places the read strobe on edge 3 of an unfiltered change. To let the whole pipeline settle, it waits at least eight edges before it reads pending state.

// File: rtl/pio_cap_pkg.sv
package pio_cap_pkg;

    localparam int REG_ADDR_W = 3;

    // Word addresses of the register port
    typedef enum logic [REG_ADDR_W-1:0] {
        REG_MASK_ON  = 3'd0,
        REG_MASK_OFF = 3'd1,
        REG_MASK     = 3'd2,
        REG_PEND     = 3'd3,
        REG_FLT_ON   = 3'd4,
        REG_FLT_OFF  = 3'd5,
        REG_FLT_STAT = 3'd6,
        REG_LEVEL    = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/pio_cap_sync.sv
module pio_cap_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pio_cap_filter.sv
module pio_cap_filter #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic last_q;
        logic lvl_q;

        // The output takes a new level only once two successive samples agree
        always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) begin
                last_q <= 1'b0;
                lvl_q  <= 1'b0;
            end else begin
                last_q <= d_i[g];
                if (d_i[g] == last_q) lvl_q <= d_i[g];
            end
        end

        assign q_o[g] = lvl_q;
    end
endmodule

// File: rtl/pio_cap_detect.sv
module pio_cap_detect #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] filt_i,
    input  logic [W-1:0] use_filt_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] change_o
);
    logic [W-1:0] prev_q;

    assign level_o = (filt_i & use_filt_i) | (raw_i & ~use_filt_i);

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) prev_q <= '0;
        else          prev_q <= level_o;
    end

    assign change_o = level_o ^ prev_q;
endmodule

// File: rtl/pio_change_irq.sv
module pio_change_irq
    import pio_cap_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_n_i,
    input  logic                  wr_en_i,
    input  logic                  rd_en_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [NLINES-1:0]     wdata_i,
    output logic [NLINES-1:0]     rdata_o,
    input  logic [NLINES-1:0]     pins_i,
    output logic                  irq_o
);
    localparam int SYNC_STAGES = 2;

    logic [NLINES-1:0] sync_w, filt_w, level_w, chg_w;
    logic [NLINES-1:0] mask_q, fen_q, pend_q, rdata_q;
    logic [NLINES-1:0] rd_mux;
    logic              pend_clr;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(addr_i);

    pio_cap_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .d_i(pins_i), .q_o(sync_w)
    );

    pio_cap_filter #(.W(NLINES)) u_filt (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .d_i(sync_w), .q_o(filt_w)
    );

    pio_cap_detect #(.W(NLINES)) u_det (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .raw_i(sync_w), .filt_i(filt_w),
        .use_filt_i(fen_q), .level_o(level_w), .change_o(chg_w)
    );

    assign pend_clr = rd_en_i && (sel == REG_PEND);

    // Mask and filter selection: set/clear addresses
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            mask_q <= '0;
            fen_q  <= '0;
        end else if (wr_en_i) begin
            unique case (sel)
                REG_MASK_ON:  mask_q <= mask_q | wdata_i;
                REG_MASK_OFF: mask_q <= mask_q & ~wdata_i;
                REG_FLT_ON:   fen_q  <= fen_q | wdata_i;
                REG_FLT_OFF:  fen_q  <= fen_q & ~wdata_i;
                default: ;
            endcase
        end
    end

    // Pending word: a same-cycle change survives the clearing read
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) pend_q <= '0;
        else          pend_q <= (pend_clr ? '0 : pend_q) | chg_w;
    end

    always_comb begin
        unique case (sel)
            REG_MASK:     rd_mux = mask_q;
            REG_PEND:     rd_mux = pend_q;
            REG_FLT_STAT: rd_mux = fen_q;
            REG_LEVEL:    rd_mux = level_w;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)     rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;
    assign irq_o   = |(pend_q & mask_q);
endmodule

// File: rtl/pio_change_irq_chk.sv
module pio_change_irq_chk
    import pio_cap_pkg::*;
#(
    parameter int NLINES = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [REG_ADDR_W-1:0] addr,
    input logic [NLINES-1:0]     wdata,
    input logic [NLINES-1:0]     rdata,
    input logic                  irq,
    input logic [NLINES-1:0]     mask,
    input logic [NLINES-1:0]     pend,
    input logic [NLINES-1:0]     fen,
    input logic [NLINES-1:0]     chg
);
    logic rd_pend;
    assign rd_pend = rd_en && (addr == REG_PEND);

    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_MASK_ON) |=> ((mask & $past(wdata)) == $past(wdata)));

    assert_mask_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_MASK_OFF) |=> ((mask & $past(wdata)) == '0));

    assert_pend_from_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(chg)) == '0));

    assert_irq_drop_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && chg == '0) |=> !irq);

    assert_read_returns_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |=> (rdata == $past(pend)));

    assert_read_keeps_new_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |=> ((pend & ~$past(chg)) == '0));

    assert_filter_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_FLT_ON) |=> ((fen & $past(wdata)) == $past(wdata)));

    assert_filter_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_FLT_OFF) |=> ((fen & $past(wdata)) == '0));
endmodule

bind pio_change_irq pio_change_irq_chk #(.NLINES(NLINES)) u_chk (
    .clk(clk_i), .rst_n(rst_n_i), .wr_en(wr_en_i), .rd_en(rd_en_i),
    .addr(addr_i), .wdata(wdata_i), .rdata(rdata_o), .irq(irq_o),
    .mask(mask_q), .pend(pend_q), .fen(fen_q), .chg(chg_w)
);

// File: tb/test_pio_change_irq.sv
module test_pio_change_irq;
    import pio_cap_pkg::*;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [N-1:0] wdata = '0, rdata, pins = '0;
    logic         irq;
    int           n_chk = 0, n_fail = 0;
    logic [N-1:0] d;

    always #5 clk = ~clk;

    pio_change_irq #(.NLINES(N)) i_pio_change_irq (
        .clk_i(clk), .rst_n_i(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pins_i(pins), .irq_o(irq)
    );

    // fields: pins, filter selection, expected pending word
    localparam logic [95:0] VEC [6] = '{
        {32'h0000_00FF, 32'h0000_0000, 32'h0000_00FF},
        {32'h0000_0F0F, 32'hFFFF_FFFF, 32'h0000_0FF0},
        {32'hA5A5_0000, 32'h0000_FFFF, 32'hA5A5_0F0F},
        {32'hFFFF_FFFF, 32'h0000_0000, 32'h5A5A_FFFF},
        {32'h0000_0000, 32'hAAAA_AAAA, 32'hFFFF_FFFF},
        {32'h8000_0001, 32'h0000_0000, 32'h8000_0001}
    };

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input reg_sel_e a, input logic [N-1:0] v);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic reg_rd(input reg_sel_e a, output logic [N-1:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(2);

        // R10: reset state
        check("R10 irq", {31'd0, irq}, '0);
        reg_rd(REG_MASK, d);     check("R10 mask", d, '0);
        reg_rd(REG_FLT_STAT, d); check("R10 filter", d, '0);
        reg_rd(REG_PEND, d);     check("R10 pend", d, '0);
        reg_rd(REG_LEVEL, d);    check("R10 level", d, '0);

        // R3/R1/R7: vector table
        for (int i = 0; i < 6; i++) begin
            reg_wr(REG_FLT_ON, VEC[i][63:32]);
            reg_wr(REG_FLT_OFF, ~VEC[i][63:32]);
            reg_rd(REG_FLT_STAT, d); check("R7 filter state", d, VEC[i][63:32]);
            wait_neg(6);
            reg_rd(REG_PEND, d);
            @(negedge clk); pins = VEC[i][95:64];
            wait_neg(8);
            reg_rd(REG_PEND, d);  check("R3 pending", d, VEC[i][31:0]);
            reg_rd(REG_LEVEL, d); check("R1 level", d, VEC[i][95:64]);
        end

        // R2/R4: mask and interrupt (pins now 0x80000001, no filtering)
        reg_wr(REG_MASK_ON, 32'h11);
        reg_rd(REG_MASK, d); check("R2 mask on", d, 32'h11);
        reg_wr(REG_MASK_OFF, 32'h01);
        reg_rd(REG_MASK, d); check("R2 mask off", d, 32'h10);
        check("R4 idle irq", {31'd0, irq}, '0);
        @(negedge clk); pins[0] = 1'b0;
        wait_neg(8);
        check("R4 unmasked line ignored", {31'd0, irq}, '0);
        reg_rd(REG_PEND, d); check("R3 falling edge", d, 32'h1);
        @(negedge clk); pins[4] = 1'b1;
        wait_neg(8);
        check("R4 masked line raises irq", {31'd0, irq}, 32'd1);
        reg_wr(REG_MASK_OFF, 32'h10);
        check("R4 mask off lowers irq", {31'd0, irq}, '0);
        reg_wr(REG_MASK_ON, 32'h10);
        check("R4 mask on raises irq", {31'd0, irq}, 32'd1);
        reg_rd(REG_PEND, d); check("R5 read value", d, 32'h10);
        check("R5 irq after clear", {31'd0, irq}, '0);
        reg_rd(REG_PEND, d); check("R5 cleared", d, '0);

        // R9: unfiltered latency (line 3)
        reg_wr(REG_MASK_ON, 32'h18);
        @(negedge clk); pins[3] = 1'b1;
        wait_neg(2); check("R9 raw early", {31'd0, irq}, '0);
        wait_neg(1); check("R9 raw due", {31'd0, irq}, 32'd1);
        reg_rd(REG_PEND, d);
        // R9: filtered latency (line 4)
        reg_wr(REG_FLT_ON, 32'h10);
        wait_neg(6);
        reg_rd(REG_PEND, d);
        @(negedge clk); pins[4] = 1'b0;
        wait_neg(4); check("R9 filtered early", {31'd0, irq}, '0);
        wait_neg(1); check("R9 filtered due", {31'd0, irq}, 32'd1);
        reg_rd(REG_PEND, d); check("R9 filtered pend", d, 32'h10);

        // R6: change coincident with clearing read (line 2, unfiltered)
        @(negedge clk); pins[2] = 1'b1;
        wait_neg(1);
        @(negedge clk); rd_en = 1'b1; addr = REG_PEND;
        @(negedge clk); rd_en = 1'b0;
        check("R6 read before event", rdata, '0);
        reg_rd(REG_PEND, d); check("R6 event kept", d, 32'h4);

        // R8: glitch filter (line 6 filtered, line 7 not)
        reg_wr(REG_FLT_ON, 32'h40);
        wait_neg(6);
        reg_rd(REG_PEND, d);
        @(negedge clk); pins[6] = 1'b1;
        @(negedge clk); pins[6] = 1'b0;
        wait_neg(8);
        reg_rd(REG_PEND, d);  check("R8 single sample rejected", d, '0);
        reg_rd(REG_LEVEL, d); check("R8 level unchanged", d & 32'h40, '0);
        @(negedge clk); pins[6] = 1'b1;
        wait_neg(2); pins[6] = 1'b0;
        wait_neg(8);
        reg_rd(REG_PEND, d);  check("R8 two samples accepted", d, 32'h40);
        @(negedge clk); pins[7] = 1'b1;
        @(negedge clk); pins[7] = 1'b0;
        wait_neg(8);
        reg_rd(REG_PEND, d);  check("R8 unfiltered pulse passes", d, 32'h80);

        finish_run();
    end
endmodule